// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 32-bit control words behind a simple word-addressed bus. The bus has a write strobe, a read strobe, a byte offset, write data and read data. Software writes values into the bank and reads them back. A handful of words come out of reset holding identification constants. A few read locations report two fixed status bits as set, on top of whatever value is stored there.

One offset acts as a command port. Writing certain values there sends a single-cycle pulse to the chip's reset controller or power controller. Offsets that fall past the end of the word array do not touch any storage. A read at such an offset returns zero, and any access there raises a one-cycle error pulse.

Read data is registered and appears one cycle after the read strobe. Writes land on the clock edge that samples the strobe.

Top module: `sysctl_regfile`

## Requirements
- R1: The bank holds 512 words of 32 bits. The word index is `bus_ofs[11:2]`, and `bus_ofs[1:0]` is ignored. An in-range write is stored at the clock edge that samples `bus_wr`. A read drives the stored word onto `bus_rdata` in the following cycle. `bus_rdata` holds its last value in cycles with no read.
- R2: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000. The stored word itself is unchanged. Reads at all other offsets, including 0x104, return the stored word as it is.
- R3: A write of 1 or 2 to byte offset 0xF00 sets `reset_req` high for exactly the next cycle.
- R4: A write of 3 to byte offset 0xF00 sets `shutdown_req` high for exactly the next cycle. No other value at 0xF00 raises either request, and no write at any other offset raises one. The two requests are never high together.
- R5: A write whose word index is 0x200 or above changes no word; in particular it does not wrap onto a low index. A read at such an index returns 0.
- R6: A read or write whose word index is 0x200 or above pulses `access_err` high for the next cycle. The command offset 0xF00 lies in this range, so a command write also pulses `access_err` and is not stored.
- R7: Reset is synchronous and active low. After reset, word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121 and word 0x43 holds 0x05F40121. Every other word holds 0. While reset is held, `bus_rdata`, `reset_req`, `shutdown_req` and `access_err` are 0.
- R8: When a read and a write to the same word fall in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_ofs | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| reset_req | output | 1 | One-cycle reset request pulse |
| shutdown_req | output | 1 | One-cycle shutdown request pulse |
| access_err | output | 1 | One-cycle out-of-range access pulse |

## Verification
Every result this block produces is due exactly one clock edge after the strobe that caused it. This covers read data, both request pulses and the error pulse. A stored write becomes visible through a read issued on the following cycle, with its data due one edge after that. The bench changes inputs on the falling edge and checks outputs at the next falling edge, which is after the single register stage and before the next strobe is sampled. Reset contents are checked right after reset is released, and checked again after a second reset in the middle of the run.

// File: rtl/sysctl_pkg.sv
// Package: shared constants for the system control register file.
// Holds the identification reset values, the status-bit read locations and
// the command codes. Assumes 32-bit words.
package sysctl_pkg;

    // Word indexes that carry identification values after reset
    localparam int unsigned ID_IDX_A = 32'h40;
    localparam int unsigned ID_IDX_B = 32'h41;
    localparam int unsigned ID_IDX_C = 32'h42;
    localparam int unsigned ID_IDX_D = 32'h43;

    localparam logic [31:0] ID_VAL_A = 32'h05F2_0121;
    localparam logic [31:0] ID_VAL_B = 32'h0000_0002;
    localparam logic [31:0] ID_VAL_C = 32'h05F3_0121;
    localparam logic [31:0] ID_VAL_D = 32'h05F4_0121;

    // Byte offsets whose reads carry forced status bits
    localparam int unsigned STAT_OFS_A = 32'h100;
    localparam int unsigned STAT_OFS_B = 32'h108;
    localparam int unsigned STAT_OFS_C = 32'h10C;

    // Command codes accepted at the command offset
    localparam logic [31:0] CMD_RESET_A  = 32'd1;
    localparam logic [31:0] CMD_RESET_B  = 32'd2;
    localparam logic [31:0] CMD_SHUTDOWN = 32'd3;

    // Value a word takes on reset, by word index
    function automatic logic [31:0] reset_word(input int unsigned idx);
        case (idx)
            ID_IDX_A: reset_word = ID_VAL_A;
            ID_IDX_B: reset_word = ID_VAL_B;
            ID_IDX_C: reset_word = ID_VAL_C;
            ID_IDX_D: reset_word = ID_VAL_D;
            default:  reset_word = 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_addr_decode.sv
// Module: sysctl_addr_decode
// Turns a byte offset into a word index. Flags whether the index is inside
// the array, whether the location carries forced status bits on reads, and
// whether it is the command location. Purely combinational.
// Assumes word-aligned offsets; the two low offset bits are dropped.
module sysctl_addr_decode #(
    parameter int unsigned OFS_W     = 12,
    parameter int unsigned NUM_WORDS = 512,
    parameter int unsigned CMD_OFS   = 32'hF00,
    localparam int unsigned IDX_W    = OFS_W - 2,
    localparam int unsigned ARR_W    = $clog2(NUM_WORDS)
) (
    input  logic [OFS_W-1:0] ofs_i,
    output logic [ARR_W-1:0] arr_idx_o,
    output logic             in_range_o,
    output logic             status_hit_o,
    output logic             cmd_hit_o
);
    import sysctl_pkg::*;

    localparam logic [IDX_W-1:0] STAT_IDX_A = IDX_W'(STAT_OFS_A >> 2);
    localparam logic [IDX_W-1:0] STAT_IDX_B = IDX_W'(STAT_OFS_B >> 2);
    localparam logic [IDX_W-1:0] STAT_IDX_C = IDX_W'(STAT_OFS_C >> 2);
    localparam logic [IDX_W-1:0] CMD_IDX    = IDX_W'(CMD_OFS >> 2);
    localparam logic [IDX_W:0]   LIMIT      = (IDX_W + 1)'(NUM_WORDS);

    logic [IDX_W-1:0] full_idx;

    // Purpose: extract the word index and classify the location
    always_comb begin
        full_idx     = ofs_i[OFS_W-1:2];
        arr_idx_o    = full_idx[ARR_W-1:0];
        in_range_o   = ({1'b0, full_idx} < LIMIT);
        status_hit_o = in_range_o &&
                       ((full_idx == STAT_IDX_A) ||
                        (full_idx == STAT_IDX_B) ||
                        (full_idx == STAT_IDX_C));
        cmd_hit_o    = (full_idx == CMD_IDX);
    end

endmodule

// File: rtl/sysctl_word_array.sv
// Module: sysctl_word_array
// Flop-based storage for the control words. Each word loads its reset value
// from the package on synchronous active-low reset and takes write data when
// its index is written. The read port is combinational and shows the value
// held before any write at the current edge.
module sysctl_word_array #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_WORDS = 512,
    localparam int unsigned ARR_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ARR_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ARR_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rword_o
);
    import sysctl_pkg::*;

    logic [DATA_W-1:0] words [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;

        // Purpose: hold one word, loaded with its reset value
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= DATA_W'(reset_word(g));
            end else if (we_i && (widx_i == ARR_W'(g))) begin
                word_q <= wdata_i;
            end
        end

        assign words[g] = word_q;
    end

    // Purpose: select the addressed word for the read path
    always_comb begin
        rword_o = words[ridx_i];
    end

    if (NUM_WORDS > ID_IDX_D) begin : g_id_chk
        AST_ID_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (words[ID_IDX_A] == DATA_W'(ID_VAL_A)) &&
                              (words[ID_IDX_B] == DATA_W'(ID_VAL_B)) &&
                              (words[ID_IDX_D] == DATA_W'(ID_VAL_D))); // R7
    end

endmodule

// File: rtl/sysctl_cmd_ctrl.sv
// Module: sysctl_cmd_ctrl
// Decodes the value written to the command location into registered
// single-cycle reset and shutdown request pulses. Assumes the caller
// flags the command location; the written value picks the request.
module sysctl_cmd_ctrl #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              cmd_hit_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              reset_req_o,
    output logic              shutdown_req_o
);
    import sysctl_pkg::*;

    logic cmd_wr;
    logic want_reset;
    logic want_off;

    // Purpose: classify a command write by its value
    always_comb begin
        cmd_wr     = wr_i && cmd_hit_i;
        want_reset = cmd_wr && ((wdata_i == DATA_W'(CMD_RESET_A)) ||
                                (wdata_i == DATA_W'(CMD_RESET_B)));
        want_off   = cmd_wr && (wdata_i == DATA_W'(CMD_SHUTDOWN));
    end

    // Purpose: register the request pulses for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req_o    <= 1'b0;
            shutdown_req_o <= 1'b0;
        end else begin
            reset_req_o    <= want_reset;
            shutdown_req_o <= want_off;
        end
    end

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_req_o && shutdown_req_o)); // R4

    AST_OFF_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req_o |-> $past(wr_i && cmd_hit_i)); // R4

endmodule

// File: rtl/sysctl_regfile.sv
// Module: sysctl_regfile (top)
// Memory-mapped bank of control words with registered read data, forced
// status bits on selected reads, a command location that raises reset or
// shutdown request pulses, and a one-cycle error pulse for accesses past
// the array. Assumes one access offset per cycle; read and write may share it.
module sysctl_regfile #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned OFS_W       = 12,
    parameter int unsigned NUM_WORDS   = 512,
    parameter int unsigned CMD_OFS     = 32'hF00,
    parameter logic [31:0] STATUS_BITS = 32'h3000_0000,
    localparam int unsigned IDX_W      = OFS_W - 2,
    localparam int unsigned ARR_W      = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [OFS_W-1:0]  bus_ofs,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_req,
    output logic              shutdown_req,
    output logic              access_err
);
    logic [ARR_W-1:0]  arr_idx;
    logic              in_range;
    logic              status_hit;
    logic              cmd_hit;
    logic [DATA_W-1:0] rword;
    logic [DATA_W-1:0] rd_next;

    sysctl_addr_decode #(
        .OFS_W     (OFS_W),
        .NUM_WORDS (NUM_WORDS),
        .CMD_OFS   (CMD_OFS)
    ) u_decode (
        .ofs_i        (bus_ofs),
        .arr_idx_o    (arr_idx),
        .in_range_o   (in_range),
        .status_hit_o (status_hit),
        .cmd_hit_o    (cmd_hit)
    );

    sysctl_word_array #(
        .DATA_W    (DATA_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_wr && in_range),
        .widx_i  (arr_idx),
        .wdata_i (bus_wdata),
        .ridx_i  (arr_idx),
        .rword_o (rword)
    );

    sysctl_cmd_ctrl #(
        .DATA_W (DATA_W)
    ) u_cmd (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_i           (bus_wr),
        .cmd_hit_i      (cmd_hit),
        .wdata_i        (bus_wdata),
        .reset_req_o    (reset_req),
        .shutdown_req_o (shutdown_req)
    );

    // Purpose: form read data, zero past the array, status bits where mapped
    always_comb begin
        if (!in_range) begin
            rd_next = '0;
        end else if (status_hit) begin
            rd_next = rword | DATA_W'(STATUS_BITS);
        end else begin
            rd_next = rword;
        end
    end

    // Purpose: register read data and the out-of-range error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            access_err <= 1'b0;
        end else begin
            if (bus_rd) begin
                bus_rdata <= rd_next;
            end
            access_err <= (bus_wr || bus_rd) && !in_range;
        end
    end

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |-> $past(bus_wr || bus_rd)); // R6

    AST_OOR_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && !in_range) |-> (bus_rdata == '0)); // R5

    AST_RST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(bus_wr) &&
                      ($past(bus_ofs[OFS_W-1:2]) == IDX_W'(CMD_OFS >> 2))); // R3

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !bus_rd) |-> $stable(bus_rdata)); // R1

endmodule

// File: tb/sysctl_regfile_tb_top.sv
// Bench for sysctl_regfile: a vector table walked by one loop, then
// directed tests for same-cycle read/write and a second reset.
module sysctl_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic        bus_rd;
    logic [11:0] bus_ofs;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        reset_req;
    logic        shutdown_req;
    logic        access_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    sysctl_regfile dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_ofs      (bus_ofs),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .reset_req    (reset_req),
        .shutdown_req (shutdown_req),
        .access_err   (access_err)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [11:0] ofs;
        logic [31:0] wd;
        logic [31:0] xrd;
        logic        xrst;
        logic        xoff;
        logic        xerr;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 12'h100, 32'h0,        32'h35F2_0121, 1'b0, 1'b0, 1'b0}, // R2 R7
        '{1'b0, 1'b1, 12'h104, 32'h0,        32'h0000_0002, 1'b0, 1'b0, 1'b0}, // R2 R7
        '{1'b0, 1'b1, 12'h108, 32'h0,        32'h35F3_0121, 1'b0, 1'b0, 1'b0}, // R2 R7
        '{1'b0, 1'b1, 12'h10C, 32'h0,        32'h35F4_0121, 1'b0, 1'b0, 1'b0}, // R2 R7
        '{1'b0, 1'b1, 12'h000, 32'h0,        32'h0000_0000, 1'b0, 1'b0, 1'b0}, // R7
        '{1'b1, 1'b0, 12'h004, 32'hDEADBEEF, 32'h0000_0000, 1'b0, 1'b0, 1'b0}, // R1
        '{1'b0, 1'b1, 12'h004, 32'h0,        32'hDEADBEEF,  1'b0, 1'b0, 1'b0}, // R1
        '{1'b1, 1'b0, 12'h100, 32'h5,        32'hDEADBEEF,  1'b0, 1'b0, 1'b0}, // R1
        '{1'b0, 1'b1, 12'h100, 32'h0,        32'h3000_0005, 1'b0, 1'b0, 1'b0}, // R2
        '{1'b1, 1'b0, 12'h7FC, 32'h12345678, 32'h3000_0005, 1'b0, 1'b0, 1'b0}, // R1
        '{1'b0, 1'b1, 12'h7FC, 32'h0,        32'h12345678,  1'b0, 1'b0, 1'b0}, // R1
        '{1'b1, 1'b0, 12'h800, 32'hFFFFFFFF, 32'h12345678,  1'b0, 1'b0, 1'b1}, // R5 R6
        '{1'b0, 1'b1, 12'h800, 32'h0,        32'h0000_0000, 1'b0, 1'b0, 1'b1}, // R5 R6
        '{1'b0, 1'b1, 12'h000, 32'h0,        32'h0000_0000, 1'b0, 1'b0, 1'b0}, // R5
        '{1'b1, 1'b0, 12'hF00, 32'h1,        32'h0000_0000, 1'b1, 1'b0, 1'b1}, // R3 R6
        '{1'b1, 1'b0, 12'hF00, 32'h2,        32'h0000_0000, 1'b1, 1'b0, 1'b1}, // R3
        '{1'b1, 1'b0, 12'hF00, 32'h3,        32'h0000_0000, 1'b0, 1'b1, 1'b1}, // R4
        '{1'b1, 1'b0, 12'hF00, 32'h4,        32'h0000_0000, 1'b0, 1'b0, 1'b1}, // R4
        '{1'b1, 1'b0, 12'hF00, 32'h0,        32'h0000_0000, 1'b0, 1'b0, 1'b1}, // R4
        '{1'b1, 1'b0, 12'hF04, 32'h1,        32'h0000_0000, 1'b0, 1'b0, 1'b1}, // R4
        '{1'b0, 1'b1, 12'hF00, 32'h0,        32'h0000_0000, 1'b0, 1'b0, 1'b1}, // R6
        '{1'b0, 1'b1, 12'h103, 32'h0,        32'h3000_0005, 1'b0, 1'b0, 1'b0}, // R1
        '{1'b1, 1'b0, 12'h10A, 32'h0,        32'h3000_0005, 1'b0, 1'b0, 1'b0}, // R1
        '{1'b0, 1'b1, 12'h108, 32'h0,        32'h3000_0000, 1'b0, 1'b0, 1'b0}, // R2
        '{1'b0, 1'b1, 12'h104, 32'h0,        32'h0000_0002, 1'b0, 1'b0, 1'b0}  // R2
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic rd,
                         input logic [11:0] ofs, input logic [31:0] wd);
        bus_wr    = wr;
        bus_rd    = rd;
        bus_ofs   = ofs;
        bus_wdata = wd;
    endtask

    // Drive at falling edge, let one rising edge pass, land on next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 12'h0, 32'h0);
        repeat (3) @(negedge clk);
        check("R7 rdata in reset", bus_rdata, 32'h0);
        check("R7 reset_req in reset", {31'h0, reset_req}, 32'h0);
        check("R7 shutdown_req in reset", {31'h0, shutdown_req}, 32'h0);
        check("R7 access_err in reset", {31'h0, access_err}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].wr, VECS[i].rd, VECS[i].ofs, VECS[i].wd);
            step();
            check($sformatf("vec %0d rdata R1/R2/R5", i), bus_rdata, VECS[i].xrd);
            check($sformatf("vec %0d reset_req R3", i), {31'h0, reset_req}, {31'h0, VECS[i].xrst});
            check($sformatf("vec %0d shutdown_req R4", i), {31'h0, shutdown_req}, {31'h0, VECS[i].xoff});
            check($sformatf("vec %0d access_err R6", i), {31'h0, access_err}, {31'h0, VECS[i].xerr});
        end

        // Idle: pulses end after one cycle, rdata holds (R3 R4 R6 R1)
        drive(1'b0, 1'b0, 12'h0, 32'h0);
        step();
        check("R3 pulse ended", {31'h0, reset_req}, 32'h0);
        check("R6 pulse ended", {31'h0, access_err}, 32'h0);
        check("R1 rdata held", bus_rdata, 32'h2);

        // R8: read and write same word together returns the older value
        drive(1'b1, 1'b1, 12'h008, 32'hAAAA_5555);
        step();
        check("R8 same-cycle read old", bus_rdata, 32'h0);
        drive(1'b0, 1'b1, 12'h008, 32'h0);
        step();
        check("R8 later read new", bus_rdata, 32'hAAAA_5555);

        // R7: second reset restores identification and clears other words
        drive(1'b0, 1'b0, 12'h0, 32'h0);
        rst_n = 1'b0;
        step();
        step();
        check("R7 rdata cleared by reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, 12'h008, 32'h0);
        step();
        check("R7 word cleared", bus_rdata, 32'h0);
        drive(1'b0, 1'b1, 12'h100, 32'h0);
        step();
        check("R7 id word restored", bus_rdata, 32'h35F2_0121);
        drive(1'b0, 1'b1, 12'h004, 32'h0);
        step();
        check("R7 written word cleared", bus_rdata, 32'h0);

        finish_run();
    end

endmodule